// File: doc/BRIEF.md
# DRAM Refresh Burst Scheduler

This block paces refresh for a DRAM system in which one refresh command refreshes every bank of every rank in parallel. A free-running interval timer, which advances only while the enable input is high, expires once per refresh period. When it expires the block pulses a one-cycle command strobe and starts a refresh burst. The burst covers a fixed number of rows, and each row takes a fixed number of cycles. While the burst runs, a busy flag holds off the normal access path.

The burst length is the number of rows in a bank divided by the number of commands in one retention window. With 262,144 rows per bank and 8,192 commands per 64 ms, each command covers 32 rows. At a 10 ns clock, with 4 cycles per row and a 780-cycle period, the block is busy for 128 of every 780 cycles, which is about 16.4 %. A row pointer holds the first row of the current or next burst. It steps by the burst length when each burst ends and wraps to row zero after the last row of the bank. A free-running counter totals the busy cycles so that the unavailable fraction can be measured.

The controller has three states. WAIT is the idle state while the timer runs. On a timer expiry it goes WAIT -> BURST and the strobe is issued. After the last cycle of the last row it goes BURST -> GAP, and the row pointer advances. GAP lasts one cycle with busy low, then it goes GAP -> WAIT unconditionally.

Top module: `refresh_burst_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, ref_strobe=0, refresh_busy=0, row_base=0 and busy_total=0.
- R2: With en held high, the first ref_strobe comes INTERVAL_CYC clock edges after reset release, and later strobes come every INTERVAL_CYC edges. Each strobe is high for exactly one cycle.
- R3: refresh_busy rises in the same cycle as ref_strobe.
- R4: refresh_busy stays high for exactly BURST_ROWS*ROW_CYC consecutive cycles per command. That is 128 cycles with the defaults.
- R5: After refresh_busy falls it stays low for at least one more cycle, the release gap, before another burst can start.
- R6: row_base holds the first row of the burst while refresh_busy is high. It grows by BURST_ROWS in the cycle in which refresh_busy falls and is unchanged at all other times.
- R7: When row_base equals ROWS_PER_BANK-BURST_ROWS, the next advance takes it to 0 rather than beyond the last row.
- R8: While en is low the interval timer is frozen and no new ref_strobe is issued. Every later strobe is delayed by exactly the number of edges for which en was low.
- R9: busy_total grows by one for each cycle in which refresh_busy is high, and the increase is visible in the next cycle. After k complete bursts it equals k*BURST_ROWS*ROW_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Lets the interval timer advance when high |
| ref_strobe | output | 1 | One-cycle pulse for each refresh command |
| row_base | output | $clog2(ROWS_PER_BANK) | First row of the current or next burst |
| refresh_busy | output | 1 | High while a burst blocks accesses |
| busy_total | output | CNT_W | Free-running total of busy cycles |

## Verification
The k-th strobe is due at edge k*INTERVAL_CYC after reset release, plus any edges for which en was low. Busy is due high at the strobe and through edge strobe+BURST_CYC-1. It is due low, with row_base advanced, at edge strobe+BURST_CYC, and busy_total reaches k*BURST_CYC at that same edge. A driver task computes each strobe's due edge, row and busy total and pushes them into a queue. A monitor counts edges since reset release and samples on the falling clock edge. It pops an item when a strobe appears and then checks the end-of-burst values at the exact edges computed from that strobe. The pause in en is placed so that the shift of every later due edge is known exactly.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } rfsh_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expire
);
    localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] tcnt;

    assign expire = en && (tcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (en) begin
            tcnt <= expire ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_burst_fsm.sv
module rfsh_burst_fsm
    import rfsh_pkg::*;
#(
    parameter int BURST_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic strobe,
    output logic busy,
    output logic burst_done
);
    localparam int BW = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1;
    localparam logic [BW-1:0] BLAST = BW'(BURST_CYC - 1);

    rfsh_state_e   state, state_nx;
    logic [BW-1:0] bcnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // cycle count inside a burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (state == ST_BURST) begin
            bcnt <= burst_done ? '0 : bcnt + 1'b1;
        end else begin
            bcnt <= '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (expire)     state_nx = ST_BURST;
            ST_BURST: if (burst_done) state_nx = ST_GAP;
            ST_GAP:                   state_nx = ST_WAIT;
            default:                  state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        strobe     = 1'b0;
        busy       = 1'b0;
        burst_done = 1'b0;
        unique case (state)
            ST_WAIT:  ;
            ST_BURST: begin
                busy       = 1'b1;
                strobe     = (bcnt == '0);
                burst_done = (bcnt == BLAST);
            end
            ST_GAP:   ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rfsh_row_ptr.sv
module rfsh_row_ptr #(
    parameter int ROWS_PER_BANK = 262144,
    parameter int BURST_ROWS    = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic [$clog2(ROWS_PER_BANK)-1:0] row_base
);
    localparam int RW = $clog2(ROWS_PER_BANK);
    localparam logic [RW-1:0] TOP  = RW'(ROWS_PER_BANK - BURST_ROWS);
    localparam logic [RW-1:0] STEP = RW'(BURST_ROWS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_base <= '0;
        end else if (advance) begin
            row_base <= (row_base == TOP) ? '0 : row_base + STEP;
        end
    end
endmodule

// File: rtl/rfsh_busy_meter.sv
module rfsh_busy_meter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    output logic [CNT_W-1:0] total
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (busy) begin
            total <= total + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_burst_sched.sv
module refresh_burst_sched #(
    parameter int INTERVAL_CYC  = 780,
    parameter int ROW_CYC       = 4,
    parameter int BURST_ROWS    = 32,
    parameter int ROWS_PER_BANK = 262144,
    parameter int CNT_W         = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en,
    output logic                             ref_strobe,
    output logic [$clog2(ROWS_PER_BANK)-1:0] row_base,
    output logic                             refresh_busy,
    output logic [CNT_W-1:0]                 busy_total
);
    localparam int BURST_CYC = BURST_ROWS * ROW_CYC;
    localparam int ROW_W     = $clog2(ROWS_PER_BANK);

    if (INTERVAL_CYC <= BURST_CYC + 1) begin : g_bad_interval
        $error("interval must exceed burst plus release gap");
    end
    if ((ROWS_PER_BANK % BURST_ROWS) != 0) begin : g_bad_rows
        $error("rows per bank must be a multiple of burst rows");
    end

    logic expire;
    logic burst_done;

    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .expire (expire)
    );

    rfsh_burst_fsm #(.BURST_CYC(BURST_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .strobe     (ref_strobe),
        .busy       (refresh_busy),
        .burst_done (burst_done)
    );

    rfsh_row_ptr #(
        .ROWS_PER_BANK (ROWS_PER_BANK),
        .BURST_ROWS    (BURST_ROWS)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (burst_done),
        .row_base (row_base)
    );

    rfsh_busy_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (refresh_busy),
        .total (busy_total)
    );
endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
    parameter int BURST_CYC     = 128,
    parameter int BURST_ROWS    = 32,
    parameter int ROWS_PER_BANK = 262144,
    parameter int ROW_W         = 18,
    parameter int CNT_W         = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ref_strobe,
    input logic [ROW_W-1:0] row_base,
    input logic             refresh_busy,
    input logic [CNT_W-1:0] busy_total
);
    localparam logic [ROW_W-1:0] TOP  = ROW_W'(ROWS_PER_BANK - BURST_ROWS);
    localparam logic [ROW_W-1:0] STEP = ROW_W'(BURST_ROWS);

    int run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= 0;
        else        run_len <= refresh_busy ? run_len + 1 : 0;
    end

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |=> !ref_strobe);

    a_r3_busy_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> refresh_busy);

    a_r4_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_busy) |-> (run_len == BURST_CYC));

    a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_busy) |=> !refresh_busy);

    a_r6_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_busy && $past(refresh_busy)) |-> $stable(row_base));

    a_r7_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_busy) |->
            (row_base == (($past(row_base) == TOP) ? '0 : $past(row_base) + STEP)));

    a_r8_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !ref_strobe);

    a_r9_busy_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy_total == $past(busy_total) + CNT_W'($past(refresh_busy)));
endmodule

bind refresh_burst_sched rfsh_checker #(
    .BURST_CYC     (BURST_CYC),
    .BURST_ROWS    (BURST_ROWS),
    .ROWS_PER_BANK (ROWS_PER_BANK),
    .ROW_W         (ROW_W),
    .CNT_W         (CNT_W)
) u_rfsh_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .ref_strobe   (ref_strobe),
    .row_base     (row_base),
    .refresh_busy (refresh_busy),
    .busy_total   (busy_total)
);

// File: tb/test_refresh_burst_sched.sv
`timescale 1ns/1ps
module test_refresh_burst_sched;
    localparam int INTERVAL_CYC  = 780;
    localparam int ROW_CYC       = 4;
    localparam int BURST_ROWS    = 32;
    localparam int ROWS_PER_BANK = 128;
    localparam int CNT_W         = 32;
    localparam int ROW_W         = $clog2(ROWS_PER_BANK);
    localparam int BURST_CYC     = BURST_ROWS * ROW_CYC;
    localparam int N_CMD         = 10;
    localparam int PAUSE_AT      = 3 * INTERVAL_CYC + 300;
    localparam int PAUSE_LEN     = 50;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             ref_strobe;
    logic [ROW_W-1:0] row_base;
    logic             refresh_busy;
    logic [CNT_W-1:0] busy_total;

    always #4 clk = ~clk;

    refresh_burst_sched #(
        .INTERVAL_CYC  (INTERVAL_CYC),
        .ROW_CYC       (ROW_CYC),
        .BURST_ROWS    (BURST_ROWS),
        .ROWS_PER_BANK (ROWS_PER_BANK),
        .CNT_W         (CNT_W)
    ) i_refresh_burst_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .ref_strobe   (ref_strobe),
        .row_base     (row_base),
        .refresh_busy (refresh_busy),
        .busy_total   (busy_total)
    );

    typedef struct {
        int due;
        int row;
        int total;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    int   end_at = -10;
    int   end_row = 0;
    int   end_total = 0;
    int   last_due = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // driver: expected strobes (R2, R7, R8, R9)
    task automatic push_expected();
        for (int k = 1; k <= N_CMD; k++) begin
            exp_t e;
            e.due   = k * INTERVAL_CYC + ((k * INTERVAL_CYC > PAUSE_AT) ? PAUSE_LEN : 0);
            e.row   = ((k - 1) * BURST_ROWS) % ROWS_PER_BANK;
            e.total = (k - 1) * BURST_CYC;
            q.push_back(e);
            last_due = e.due;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_strobe) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected strobe", cyc, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due, (e.due > PAUSE_AT) ? "R8" : "R2",
                          "strobe edge", cyc, e.due);
                    check(refresh_busy == 1'b1, "R3", "busy at strobe",
                          int'(refresh_busy), 1);
                    check(int'(row_base) == e.row, "R6", "row at strobe",
                          int'(row_base), e.row);
                    check(int'(busy_total) == e.total, "R9", "total at strobe",
                          int'(busy_total), e.total);
                    end_at    = cyc + BURST_CYC;
                    end_row   = (e.row + BURST_ROWS) % ROWS_PER_BANK;
                    end_total = e.total + BURST_CYC;
                end
            end
            if (cyc == end_at - 1)
                check(refresh_busy == 1'b1, "R4", "busy on last burst cycle",
                      int'(refresh_busy), 1);
            if (cyc == end_at) begin
                check(refresh_busy == 1'b0, "R4", "busy after burst",
                      int'(refresh_busy), 0);
                check(int'(row_base) == end_row, (end_row == 0) ? "R7" : "R6",
                      "row after burst", int'(row_base), end_row);
                check(int'(busy_total) == end_total, "R9", "total after burst",
                      int'(busy_total), end_total);
            end
            if (cyc == end_at + 1)
                check(refresh_busy == 1'b0, "R5", "release gap",
                      int'(refresh_busy), 0);
        end
    end

    initial begin
        push_expected();
        repeat (3) @(negedge clk);
        check(ref_strobe == 1'b0, "R1", "strobe in reset", int'(ref_strobe), 0);
        check(refresh_busy == 1'b0, "R1", "busy in reset", int'(refresh_busy), 0);
        check(row_base == '0, "R1", "row in reset", int'(row_base), 0);
        check(busy_total == '0, "R1", "total in reset", int'(busy_total), 0);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        check(ref_strobe == 1'b0 && refresh_busy == 1'b0, "R1",
              "outputs after release", int'(refresh_busy), 0);
        // R8: pause the enable while the controller waits
        wait (cyc == PAUSE_AT);
        @(negedge clk);
        en = 1'b0;
        repeat (PAUSE_LEN) @(negedge clk);
        check(ref_strobe == 1'b0, "R8", "no strobe while disabled",
              int'(ref_strobe), 0);
        en = 1'b1;
        wait (cyc >= last_due + BURST_CYC + 5);
        @(negedge clk);
        check(q.size() == 0, "R2", "strobes outstanding", q.size(), 0);
        check(int'(busy_total) == N_CMD * BURST_CYC, "R9", "final busy total",
              int'(busy_total), N_CMD * BURST_CYC);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R2 watchdog: edge %0d reached, expected end by %0d",
                     cyc, last_due + BURST_CYC + 5);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule